// File: doc/BRIEF.md
# Sparsified Macropixel Readout Controller

This block is the periphery readout for a binary pixel matrix of 32 by 128 pixels, tiled into 4x4-pixel macropixels (256 of them). Each macropixel raises its own hit request line as long as its pixel latches hold a hit. Each macropixel also listens to its own enable line from the periphery. On the readout clock the controller synchronizes these requests and marks a macropixel as pending on the rising edge of its request. At that moment it also stores a copy of the timestamp, which counts cycles of a separate bunch-crossing clock and crosses into the readout domain in Gray code.

Pending macropixels are served one at a time, lowest address first. The selected macropixel gets its private enable. The controller then steps a set of shared column-select lines across its four pixel columns and samples the shared 4-bit data lines. A column with no hit pixel produces nothing. Every other column becomes one output word that carries the timestamp, the macropixel address, the column index and the 4-bit hit pattern. After the last column, a shared latch-clear strobe is raised for one cycle while the enable is still held. At the next edge the enable and the pending mark both drop. The output is a single-register valid/ready port, and backpressure stalls the column stepping.

Top module: `mpx_readout`

## Requirements
- R1: While the readout reset is asserted and right after it, `out_valid`, `latch_clr`, every `mp_en` bit and every `col_en` bit are 0.
- R2: The timestamp counts bunch-crossing clock cycles since `bc_rst_n` was released, modulo 2^TS_W, and wraps from all ones to 0. A word carries the count that was current when its macropixel's request rose. This holds for a request that rises at least SYNC_STAGES readout cycles away from a bunch-crossing edge. Between consecutive bunch-crossing cycles the Gray-coded count changes in exactly one bit.
- R3: `out_word` is {timestamp[TS_W-1:0], address[7:0], column[1:0], pattern[3:0]}, with the most significant field first. The address is the index of the request line. Pattern bit r is pixel row r of the selected column, as returned on `col_data` while `col_en` bit `column` is high.
- R4: At most one `mp_en` bit is high at any time. At most one `col_en` bit is high, and only while some `mp_en` bit is high.
- R5: When several macropixels are pending, the one with the lowest address is served first.
- R6: A new hit in a macropixel that is already pending creates no second request. Its pixels are read as part of the pending entry, with the timestamp of the first hit.
- R7: The columns of the served macropixel are visited in ascending order. A column whose four bits are all zero produces no word. Each other column produces exactly one word.
- R8: Once the columns are read, `latch_clr` is high for exactly one cycle while the served `mp_en` bit is still high. In the next cycle every `mp_en` bit is 0, and the macropixel is no longer pending.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` keeps its value. No word is lost or duplicated under any pattern of `out_ready`.
- R10: With every pixel of the matrix hit at once, all 1024 column words come out, in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bc_clk | input | 1 | Bunch-crossing clock for the timestamp counter |
| bc_rst_n | input | 1 | Active-low asynchronous reset of the bunch-crossing domain |
| rd_clk | input | 1 | Readout clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset of the readout domain |
| mp_req | input | 256 | Private hit request line per macropixel, level |
| mp_en | output | 256 | Private readout enable line per macropixel |
| col_en | output | 4 | Shared one-hot column select |
| col_data | input | 4 | Shared pixel data lines, driven by the enabled macropixel |
| latch_clr | output | 1 | Shared strobe that clears the enabled macropixel's latches |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | 22 | {timestamp, address, column, pattern} |

## Verification
A single macropixel with a scattered pattern that leaves two columns empty separates correct sparsification from plain column dumping. The same stimulus at the top address exposes address truncation. A batch of unordered addresses raised in the same cycle tells a priority pick apart from arrival order. A later hit added to a still-pending macropixel, one bunch-crossing cycle after the first, separates merging from re-requesting, because the timestamp differs. A batch read under a pseudo-random `out_ready` checks stalls for loss or repeats. Hits placed at the counter's all-ones and zero values check the wrap. A full-occupancy flood checks the 100% case and the ordering over all 256 addresses.

// File: rtl/mpx_pkg.sv
package mpx_pkg;

   // Readout sequencer states
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_COL  = 2'd1,
      SQ_CLR  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/mpx_ts_gen.sv
// Bunch-crossing timestamp counter, published in Gray code for the crossing.
module mpx_ts_gen #(
   parameter int TS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] ts_gray
);

   logic [TS_W-1:0] cnt_q;
   logic [TS_W-1:0] cnt_nx;

   assign cnt_nx = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ts_gray <= '0;
      end else begin
         cnt_q   <= cnt_nx;
         ts_gray <= cnt_nx ^ (cnt_nx >> 1);
      end
   end

endmodule

// File: rtl/mpx_sync.sv
// Multi-stage flop synchronizer (per-bit; only for levels or Gray-coded buses).
module mpx_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/mpx_hit_reg.sv
// Pending-hit register: edge detect per request, timestamp slot per macropixel,
// lowest-address priority pick.
module mpx_hit_reg #(
   parameter int NUM_MP = 256,
   parameter int TS_W   = 8,
   localparam int ADDR_W = $clog2(NUM_MP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_MP-1:0] req_s,
   input  logic [TS_W-1:0]   ts_gray_s,
   input  logic              clr_stb,
   input  logic [ADDR_W-1:0] clr_idx,
   input  logic [ADDR_W-1:0] rd_idx,
   output logic              any_pend,
   output logic [ADDR_W-1:0] pend_idx,
   output logic [TS_W-1:0]   ts_sel
);

   logic [NUM_MP-1:0]      req_d;
   logic [NUM_MP-1:0]      rise;
   logic [NUM_MP-1:0]      pend_q;
   logic [NUM_MP-1:0]      clr_vec;
   logic [TS_W-1:0]        ts_bin;
   logic [NUM_MP*TS_W-1:0] ts_flat;

   // Gray to binary: each bit is the parity of itself and all higher bits
   always_comb begin
      for (int b = 0; b < TS_W; b++) ts_bin[b] = ^(ts_gray_s >> b);
   end

   assign rise    = req_s & ~req_d;
   assign clr_vec = clr_stb ? ({{(NUM_MP-1){1'b0}}, 1'b1} << clr_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_d  <= '0;
         pend_q <= '0;
      end else begin
         req_d  <= req_s;
         pend_q <= (pend_q & ~clr_vec) | rise;
      end
   end

   for (genvar i = 0; i < NUM_MP; i++) begin : g_slot
      logic [TS_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       slot_q <= '0;
         else if (rise[i]) slot_q <= ts_bin;
      end
      assign ts_flat[i*TS_W +: TS_W] = slot_q;
   end

   assign ts_sel   = ts_flat[rd_idx*TS_W +: TS_W];
   assign any_pend = |pend_q;

   always_comb begin
      pend_idx = '0;
      for (int i = NUM_MP-1; i >= 0; i--) begin
         if (pend_q[i]) pend_idx = ADDR_W'(i);
      end
   end

endmodule

// File: rtl/mpx_readout_seq.sv
// Column sequencer with sparsification and a single-register output port.
module mpx_readout_seq
   import mpx_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int TS_W   = 8,
   parameter int MP_DIM = 4,
   localparam int COL_W  = $clog2(MP_DIM),
   localparam int WORD_W = TS_W + ADDR_W + COL_W + MP_DIM
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_pend,
   input  logic [ADDR_W-1:0] pend_idx,
   input  logic [TS_W-1:0]   ts_sel,
   input  logic [MP_DIM-1:0] col_data,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] sel_idx,
   output logic              en_act,
   output logic [MP_DIM-1:0] col_en,
   output logic              clr_stb,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word
);

   seq_state_e       st_q;
   logic [COL_W-1:0] col_q;
   logic             last_col;
   logic             slot_free;
   logic             take;
   logic             load;

   assign last_col  = (col_q == COL_W'(MP_DIM-1));
   assign slot_free = !out_valid || out_ready;
   assign take      = (st_q == SQ_COL) && slot_free;
   assign load      = take && (|col_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         sel_idx <= '0;
         col_q   <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               if (any_pend) begin
                  sel_idx <= pend_idx;
                  col_q   <= '0;
                  st_q    <= SQ_COL;
               end
            end
            SQ_COL: begin
               if (take) begin
                  if (last_col) st_q  <= SQ_CLR;
                  else          col_q <= col_q + 1'b1;
               end
            end
            SQ_CLR:  st_q <= SQ_IDLE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_word  <= {ts_sel, sel_idx, col_q, col_data};
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assign en_act  = (st_q != SQ_IDLE);
   assign col_en  = (st_q == SQ_COL) ? (MP_DIM'(1) << col_q) : '0;
   assign clr_stb = (st_q == SQ_CLR);

endmodule

// File: rtl/mpx_readout.sv
module mpx_readout #(
   parameter int PIX_ROWS    = 32,
   parameter int PIX_COLS    = 128,
   parameter int MP_DIM      = 4,
   parameter int TS_W        = 8,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_MP = (PIX_ROWS / MP_DIM) * (PIX_COLS / MP_DIM),
   localparam int ADDR_W = $clog2(NUM_MP),
   localparam int COL_W  = $clog2(MP_DIM),
   localparam int WORD_W = TS_W + ADDR_W + COL_W + MP_DIM
) (
   input  logic              bc_clk,
   input  logic              bc_rst_n,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic [NUM_MP-1:0] mp_req,
   output logic [NUM_MP-1:0] mp_en,
   output logic [MP_DIM-1:0] col_en,
   input  logic [MP_DIM-1:0] col_data,
   output logic              latch_clr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word
);

   if (PIX_ROWS % MP_DIM != 0 || PIX_COLS % MP_DIM != 0) begin : g_bad_tile
      $error("matrix size must be a whole number of macropixels");
   end
   if (MP_DIM < 2) begin : g_bad_dim
      $error("macropixel edge must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end
   if (TS_W < 2) begin : g_bad_ts
      $error("timestamp must be at least 2 bits");
   end

   logic [TS_W-1:0]   bc_ts_gray;
   logic [TS_W-1:0]   ts_gray_s;
   logic [NUM_MP-1:0] req_s;
   logic              any_pend;
   logic [ADDR_W-1:0] pend_idx;
   logic [ADDR_W-1:0] sel_idx;
   logic [TS_W-1:0]   ts_sel;
   logic              en_act;
   logic              clr_stb;

   mpx_ts_gen #(.TS_W(TS_W)) u_ts (
      .clk     (bc_clk),
      .rst_n   (bc_rst_n),
      .ts_gray (bc_ts_gray)
   );

   mpx_sync #(.W(TS_W), .STAGES(SYNC_STAGES)) u_ts_sync (
      .clk   (rd_clk),
      .rst_n (rd_rst_n),
      .d     (bc_ts_gray),
      .q     (ts_gray_s)
   );

   mpx_sync #(.W(NUM_MP), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (rd_clk),
      .rst_n (rd_rst_n),
      .d     (mp_req),
      .q     (req_s)
   );

   mpx_hit_reg #(.NUM_MP(NUM_MP), .TS_W(TS_W)) u_hits (
      .clk       (rd_clk),
      .rst_n     (rd_rst_n),
      .req_s     (req_s),
      .ts_gray_s (ts_gray_s),
      .clr_stb   (clr_stb),
      .clr_idx   (sel_idx),
      .rd_idx    (sel_idx),
      .any_pend  (any_pend),
      .pend_idx  (pend_idx),
      .ts_sel    (ts_sel)
   );

   mpx_readout_seq #(.ADDR_W(ADDR_W), .TS_W(TS_W), .MP_DIM(MP_DIM)) u_seq (
      .clk       (rd_clk),
      .rst_n     (rd_rst_n),
      .any_pend  (any_pend),
      .pend_idx  (pend_idx),
      .ts_sel    (ts_sel),
      .col_data  (col_data),
      .out_ready (out_ready),
      .sel_idx   (sel_idx),
      .en_act    (en_act),
      .col_en    (col_en),
      .clr_stb   (clr_stb),
      .out_valid (out_valid),
      .out_word  (out_word)
   );

   assign mp_en     = en_act ? ({{(NUM_MP-1){1'b0}}, 1'b1} << sel_idx) : '0;
   assign latch_clr = clr_stb;

endmodule

// File: rtl/mpx_readout_chk.sv
module mpx_readout_chk #(
   parameter int NUM_MP = 256,
   parameter int MP_DIM = 4,
   parameter int TS_W   = 8,
   parameter int WORD_W = 22
) (
   input logic              bc_clk,
   input logic              bc_rst_n,
   input logic              rd_clk,
   input logic              rd_rst_n,
   input logic [NUM_MP-1:0] mp_en,
   input logic [MP_DIM-1:0] col_en,
   input logic              latch_clr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_word,
   input logic [TS_W-1:0]   bc_ts_gray
);

   // R2: Gray timestamp moves by exactly one bit per bunch-crossing cycle
   a_r2_gray_step: assert property (@(posedge bc_clk) disable iff (!bc_rst_n)
      $past(bc_rst_n) |-> $countones(bc_ts_gray ^ $past(bc_ts_gray)) == 1);

   // R4: one macropixel enabled at most
   a_r4_single_en: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $onehot0(mp_en));

   // R4: one column selected at most
   a_r4_single_col: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $onehot0(col_en));

   // R4: column select only under an enabled macropixel
   a_r4_col_needs_en: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (|col_en) |-> (|mp_en));

   // R8: clear strobe only while the served macropixel is enabled
   a_r8_clr_with_en: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      latch_clr |-> ((|mp_en) && col_en == '0));

   // R8: enable and strobe both gone in the following cycle
   a_r8_en_drops: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      latch_clr |=> (mp_en == '0 && !latch_clr));

   // R9: stalled word is held
   a_r9_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

endmodule

bind mpx_readout mpx_readout_chk #(
   .NUM_MP (NUM_MP),
   .MP_DIM (MP_DIM),
   .TS_W   (TS_W),
   .WORD_W (WORD_W)
) u_chk (
   .bc_clk     (bc_clk),
   .bc_rst_n   (bc_rst_n),
   .rd_clk     (rd_clk),
   .rd_rst_n   (rd_rst_n),
   .mp_en      (mp_en),
   .col_en     (col_en),
   .latch_clr  (latch_clr),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_word   (out_word),
   .bc_ts_gray (bc_ts_gray)
);

// File: tb/sim_mpx_readout.sv
`timescale 1ns/1ps
module sim_mpx_readout;

   localparam int NUM_MP = 256;
   localparam int MP_DIM = 4;
   localparam int TS_W   = 8;
   localparam int WORD_W = 22;
   localparam int PIX_N  = MP_DIM * MP_DIM;

   logic              bc_clk = 1'b0;
   logic              rd_clk = 1'b0;
   logic              bc_rst_n = 1'b0;
   logic              rd_rst_n = 1'b0;
   logic [NUM_MP-1:0] mp_req;
   logic [NUM_MP-1:0] mp_en;
   logic [MP_DIM-1:0] col_en;
   logic [MP_DIM-1:0] col_data;
   logic              latch_clr;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic [WORD_W-1:0] out_word;

   int checks = 0;
   int fails  = 0;
   string cur_req = "R3";

   mpx_readout u0 (
      .bc_clk    (bc_clk),
      .bc_rst_n  (bc_rst_n),
      .rd_clk    (rd_clk),
      .rd_rst_n  (rd_rst_n),
      .mp_req    (mp_req),
      .mp_en     (mp_en),
      .col_en    (col_en),
      .col_data  (col_data),
      .latch_clr (latch_clr),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_word  (out_word)
   );

   // 125 MHz readout clock; bunch-crossing clock at a quarter rate, offset
   always #4 rd_clk = ~rd_clk;
   initial begin
      #1;
      forever #16 bc_clk = ~bc_clk;
   end

   // ---------------- front-end model ----------------
   logic [PIX_N-1:0] pix [NUM_MP];

   always_comb begin
      for (int i = 0; i < NUM_MP; i++) mp_req[i] = |pix[i];
   end

   always_comb begin
      col_data = '0;
      for (int i = 0; i < NUM_MP; i++) begin
         for (int c = 0; c < MP_DIM; c++) begin
            if (mp_en[i] && col_en[c]) col_data = col_data | pix[i][c*MP_DIM +: MP_DIM];
         end
      end
   end

   // latches of the enabled macropixel are cleared by the strobe (R8)
   always @(negedge rd_clk) begin
      if (latch_clr) begin
         for (int i = 0; i < NUM_MP; i++) if (mp_en[i]) pix[i] = '0;
      end
   end

   // bench timestamp reference (R2)
   int tb_ts = 0;
   always @(posedge bc_clk) if (bc_rst_n) tb_ts = (tb_ts + 1) % (1 << TS_W);

   // ---------------- scoreboard ----------------
   logic [WORD_W-1:0] exp_q [$];
   int served_exp = 0;
   int clr_pulses = 0;
   int multi_en   = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push_words(input int idx, input logic [PIX_N-1:0] pat, input int ts);
      for (int c = 0; c < MP_DIM; c++) begin
         if (pat[c*MP_DIM +: MP_DIM] != '0)
            exp_q.push_back({TS_W'(ts), 8'(idx), 2'(c), pat[c*MP_DIM +: MP_DIM]});
      end
   endtask

   logic [PIX_N-1:0] batch_pat [NUM_MP];

   // Called at a bunch-crossing falling edge; raises all batch hits at once.
   // Entry 'defer' is raised but its words are pushed by the caller.
   task automatic fire_batch(input int defer, output int ts_at);
      ts_at = tb_ts;
      for (int i = 0; i < NUM_MP; i++) begin
         if (batch_pat[i] != '0) begin
            pix[i] = pix[i] | batch_pat[i];
            served_exp++;
            if (i != defer) push_words(i, batch_pat[i], tb_ts);
         end
         batch_pat[i] = '0;
      end
   endtask

   task automatic drain(input string req);
      int idle = 0;
      int guard = 0;
      while (idle < 8 && guard < 20000) begin
         @(negedge rd_clk);
         guard++;
         if (exp_q.size() == 0 && mp_en == '0 && !out_valid) idle++;
         else idle = 0;
      end
      check(exp_q.size() == 0, req, "words still expected", exp_q.size(), 0);
   endtask

   // monitor: pops and compares at each accepted transfer
   always @(negedge rd_clk) begin
      if (rd_rst_n) begin
         if ($countones(mp_en) > 1) multi_en++;
         if (latch_clr) clr_pulses++;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, cur_req, "unexpected word", longint'(out_word), 0);
            end else begin
               logic [WORD_W-1:0] e;
               e = exp_q.pop_front();
               check(out_word == e, cur_req, "word", longint'(out_word), longint'(e));
            end
         end
      end
   end

   // backpressure: pseudo-random when stall_on (R9)
   bit stall_on = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   always @(posedge rd_clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= stall_on ? lfsr[0] : 1'b1;
   end

   // watchdog
   initial begin
      #960000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int ts0;
      int ts_merge;
      for (int i = 0; i < NUM_MP; i++) begin
         pix[i] = '0;
         batch_pat[i] = '0;
      end
      #50;
      // R1: reset state
      check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      check(mp_en == '0, "R1", "mp_en in reset", longint'($countones(mp_en)), 0);
      check(col_en == '0, "R1", "col_en in reset", col_en, 0);
      check(latch_clr == 1'b0, "R1", "latch_clr in reset", latch_clr, 0);
      #3 bc_rst_n = 1'b1;
      #8 rd_rst_n = 1'b1;
      repeat (3) @(negedge rd_clk);
      check(out_valid == 1'b0 && mp_en == '0, "R1", "idle after reset",
            longint'(out_valid), 0);

      // R3, R7: scattered pattern, columns 0 and 2 empty
      cur_req = "R7";
      @(negedge bc_clk);
      batch_pat[5] = 16'hA0C0;
      fire_batch(-1, ts0);
      drain("R7");

      // R3: top address, all columns
      cur_req = "R3";
      @(negedge bc_clk);
      batch_pat[255] = 16'h9F18;
      fire_batch(-1, ts0);
      drain("R3");
      check(pix[255] == '0, "R8", "latches of served macropixel", pix[255], 0);

      // R5: unordered addresses raised together
      cur_req = "R5";
      @(negedge bc_clk);
      batch_pat[200] = 16'h0001;
      batch_pat[3]   = 16'h8000;
      batch_pat[77]  = 16'h0F0F;
      batch_pat[128] = 16'h1234;
      fire_batch(-1, ts0);
      drain("R5");

      // R6: merge into a still-pending entry, later timestamp must not appear
      cur_req = "R6";
      @(negedge bc_clk);
      for (int i = 0; i < 8; i++) batch_pat[i] = 16'hFFFF;
      batch_pat[200] = 16'h000F;
      fire_batch(200, ts_merge);
      @(negedge bc_clk);
      pix[200] = pix[200] | 16'h0F00;
      push_words(200, 16'h0F0F, ts_merge);
      drain("R6");

      // R9: stalls under pseudo-random ready
      cur_req = "R9";
      stall_on = 1'b1;
      @(negedge bc_clk);
      for (int i = 40; i < 56; i++) batch_pat[i] = 16'(16'h1111 * ((i % 15) + 1));
      fire_batch(-1, ts0);
      drain("R9");
      stall_on = 1'b0;

      // R2: wrap of the timestamp
      cur_req = "R2";
      do @(negedge bc_clk); while (tb_ts != (1 << TS_W) - 1);
      batch_pat[9] = 16'h00F0;
      fire_batch(-1, ts0);
      check(ts0 == (1 << TS_W) - 1, "R2", "bench at counter top", ts0, (1 << TS_W) - 1);
      @(negedge bc_clk);
      batch_pat[10] = 16'h0F00;
      fire_batch(-1, ts0);
      check(ts0 == 0, "R2", "bench at counter zero", ts0, 0);
      drain("R2");

      // R10: full occupancy
      cur_req = "R10";
      @(negedge bc_clk);
      for (int i = 0; i < NUM_MP; i++) batch_pat[i] = '1;
      fire_batch(-1, ts0);
      check(exp_q.size() == NUM_MP * MP_DIM, "R10", "expected words queued",
            exp_q.size(), NUM_MP * MP_DIM);
      drain("R10");

      // R8, R4: final bookkeeping at the ports
      begin
         int left = 0;
         for (int i = 0; i < NUM_MP; i++) if (pix[i] != '0) left++;
         check(left == 0, "R8", "macropixels not cleared", left, 0);
      end
      check(clr_pulses == served_exp, "R8", "clear strobes vs services",
            clr_pulses, served_exp);
      check(multi_en == 0, "R4", "cycles with several enables", multi_en, 0);
      check(mp_en == '0 && col_en == '0, "R4", "selects idle at end",
            longint'($countones(mp_en)), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule